// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This core is a small processor that runs a program held in an internal instruction memory. It works on an accumulator and an auxiliary register, and it reads and writes a word-addressed internal data memory. Each instruction passes through three clock cycles in a fixed order: fetch, then decode with the operand read, then execute. The instruction set has an add-from-memory instruction, a store-and-clear instruction, a memory increment that skips the next instruction when the result is zero, and an unconditional jump. It also has an operate group whose three flags can increment the accumulator, skip on a zero accumulator and swap the accumulator with the auxiliary register, all within one instruction.

A host fills both memories through the load port while reset is held. It then releases reset and watches the program counter, the accumulator and the auxiliary register on the observation outputs. The data memory can only be observed through the program itself, for example by adding a stored word back into a cleared accumulator. All arithmetic wraps modulo 2^DATA_W, and there is no carry flag.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC, AC and AX become zero. A write on the load port goes to the instruction memory (`ld_data_sel`=0) or to the data memory (`ld_data_sel`=1, low DATA_W bits of `ld_word`) at `ld_addr`.
- R2: An instruction word is IW = ADDR_W+6 bits. From the MSB down it holds a 3-bit opcode, the ADDR_W-bit address A, and then the F0, F1 and F2 flags, with F2 in bit 0.
- R3: Opcode 0 adds the data word at A into AC, wrapping modulo 2^DATA_W.
- R4: Opcode 1 writes AC to the data word at A and then clears AC to zero.
- R5: Opcode 2 increments the data word at A, wrapping. When the new value is zero, PC advances one extra step, so the next instruction is skipped.
- R6: Opcode 3 loads PC with A.
- R7: Opcode 7 with F0 set increments AC.
- R8: Opcode 7 with F1 set skips the next instruction when AC is zero. The test uses AC after any F0 increment in the same instruction.
- R9: Opcode 7 with F2 set exchanges AC and AX. The value moved into AX is AC after any F0 increment.
- R10: Opcodes 4, 5 and 6 change neither AC, AX nor the data memory. They only advance PC by one.
- R11: Each instruction takes exactly three clock cycles after reset is released. PC advances by one per instruction unless a jump or skip applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load port write strobe |
| ld_data_sel | input | 1 | 0 selects instruction memory, 1 selects data memory |
| ld_addr | input | ADDR_W | Load address |
| ld_word | input | max(IW,DATA_W) | Load value |
| pc_o | output | ADDR_W | Program counter |
| ac_o | output | DATA_W | Accumulator |
| ax_o | output | DATA_W | Auxiliary register |

## Verification
In a single operate instruction, the F0 increment and the F1 zero test happen in the same execute cycle, and the F2 exchange uses the result of that increment. The bench loads all ones into AC and issues one operate word with all three flags set. The increment must wrap AC to zero, the skip must then take effect, and the zero must land in AX. The result is judged from PC, AC and AX after that instruction. In the same way, the memory increment and its skip fall in one cycle. The bench provokes this with an all-ones data word, and it confirms the written value by adding it back into AC.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2
  } seq_t;

  localparam int OPC_W = 3;
  localparam int FLG_W = 3;

  localparam logic [OPC_W-1:0] OPC_ADD  = 3'd0;
  localparam logic [OPC_W-1:0] OPC_STCL = 3'd1;
  localparam logic [OPC_W-1:0] OPC_INCZ = 3'd2;
  localparam logic [OPC_W-1:0] OPC_JUMP = 3'd3;
  localparam logic [OPC_W-1:0] OPC_OPER = 3'd7;
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/acc_opgroup.sv
module acc_opgroup #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ac_in,
  input  logic [DW-1:0] ax_in,
  input  logic          inc_en,
  input  logic          zskip_en,
  input  logic          swap_en,
  output logic [DW-1:0] ac_out,
  output logic [DW-1:0] ax_out,
  output logic          skip
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] stage1;

  always_comb begin
    stage1 = inc_en ? ac_in + ONE : ac_in;
    skip   = zskip_en && (stage1 == '0);
    ac_out = swap_en ? ax_in : stage1;
    ax_out = swap_en ? stage1 : ax_in;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int IW   = OPC_W + ADDR_W + FLG_W,
  localparam int LD_W = (IW > DATA_W) ? IW : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_data_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LD_W-1:0]   ld_word,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] ax_o
);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
  localparam logic [DATA_W-1:0] D_ONE  = DATA_W'(1);

  seq_t              state;
  logic [IW-1:0]     ir;
  logic [IW-1:0]     imem_q;
  logic [DATA_W-1:0] dmem_q;

  logic [OPC_W-1:0]  ir_op;
  logic [ADDR_W-1:0] ir_a;
  logic              ir_f0, ir_f1, ir_f2;
  logic [ADDR_W-1:0] fetched_a;

  assign ir_op     = ir[IW-1 -: OPC_W];
  assign ir_a      = ir[FLG_W +: ADDR_W];
  assign ir_f0     = ir[2];
  assign ir_f1     = ir[1];
  assign ir_f2     = ir[0];
  assign fetched_a = imem_q[FLG_W +: ADDR_W];

  logic exec;
  assign exec = (state == ST_EXEC);

  logic [DATA_W-1:0] mem_inc;
  assign mem_inc = dmem_q + D_ONE;

  logic imem_we;
  assign imem_we = ld_en && !ld_data_sel;

  acc_ram #(.AW(ADDR_W), .DW(IW)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (ld_addr),
    .wdata (ld_word[IW-1:0]),
    .raddr (pc_o),
    .rdata (imem_q)
  );

  logic              dmem_we;
  logic [ADDR_W-1:0] dmem_waddr;
  logic [DATA_W-1:0] dmem_wdata;

  always_comb begin
    dmem_we    = 1'b0;
    dmem_waddr = ir_a;
    dmem_wdata = ac_o;
    if (ld_en && ld_data_sel) begin
      dmem_we    = 1'b1;
      dmem_waddr = ld_addr;
      dmem_wdata = ld_word[DATA_W-1:0];
    end else if (exec && !rst) begin
      if (ir_op == OPC_STCL) begin
        dmem_we    = 1'b1;
        dmem_wdata = ac_o;
      end else if (ir_op == OPC_INCZ) begin
        dmem_we    = 1'b1;
        dmem_wdata = mem_inc;
      end
    end
  end

  acc_ram #(.AW(ADDR_W), .DW(DATA_W)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr (fetched_a),
    .rdata (dmem_q)
  );

  logic [DATA_W-1:0] og_ac, og_ax;
  logic              og_skip;

  acc_opgroup #(.DW(DATA_W)) u_opgroup (
    .ac_in    (ac_o),
    .ax_in    (ax_o),
    .inc_en   (ir_f0),
    .zskip_en (ir_f1),
    .swap_en  (ir_f2),
    .ac_out   (og_ac),
    .ax_out   (og_ax),
    .skip     (og_skip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc_o  <= '0;
      ac_o  <= '0;
      ax_o  <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= imem_q;
          pc_o  <= pc_o + PC_ONE;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          case (ir_op)
            OPC_ADD:  ac_o <= ac_o + dmem_q;
            OPC_STCL: ac_o <= '0;
            OPC_INCZ: if (mem_inc == '0) pc_o <= pc_o + PC_ONE;
            OPC_JUMP: pc_o <= ir_a;
            OPC_OPER: begin
              ac_o <= og_ac;
              ax_o <= og_ax;
              if (og_skip) pc_o <= pc_o + PC_ONE;
            end
            default: ;
          endcase
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  AST_ADD_INTO_AC: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_ADD) |=> ac_o == $past(ac_o + dmem_q)); // R3

  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_STCL) |=> ac_o == '0); // R4

  AST_INCZ_SKIP: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_INCZ && dmem_q == '1) |=> pc_o == $past(pc_o) + PC_ONE); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_JUMP) |=> pc_o == $past(ir_a)); // R6

  AST_OPER_INC: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_OPER && ir_f0 && !ir_f2) |=> ac_o == $past(ac_o) + D_ONE); // R7

  AST_OPER_WRAP_SKIP: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_OPER && ir_f0 && ir_f1 && ac_o == '1) |=> pc_o == $past(pc_o) + PC_ONE); // R8

  AST_OPER_SWAP: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op == OPC_OPER && ir_f2 && !ir_f0) |=> (ac_o == $past(ax_o) && ax_o == $past(ac_o))); // R9

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exec && ir_op >= 3'd4 && ir_op <= 3'd6) |=> ($stable(ac_o) && $stable(ax_o) && pc_o == $past(pc_o))); // R10

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE) |=> (pc_o == $past(pc_o) + PC_ONE && state == ST_EXEC)); // R11
endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int IW     = 3 + ADDR_W + 3;
  localparam int LD_W   = (IW > DATA_W) ? IW : DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic              ld_data_sel = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [LD_W-1:0]   ld_word = '0;
  logic [ADDR_W-1:0] pc_o;
  logic [DATA_W-1:0] ac_o, ax_o;

  int n_chk = 0;
  int n_bad = 0;

  acc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data_sel(ld_data_sel),
    .ld_addr(ld_addr), .ld_word(ld_word), .pc_o(pc_o), .ac_o(ac_o), .ax_o(ax_o)
  );

  always #4 clk = ~clk;

  function automatic logic [LD_W-1:0] enc(input int op, input int a,
                                          input bit f0, input bit f1, input bit f2);
    logic [IW-1:0] w;
    w = {3'(op), ADDR_W'(a), f0, f1, f2};
    return LD_W'(w);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input bit to_data, input int addr, input logic [LD_W-1:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_data_sel = to_data; ld_addr = ADDR_W'(addr); ld_word = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // hold reset and fill program memory with reserved opcode 4 (no-op)
  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < (1 << ADDR_W); i++) load(1'b0, i, enc(4, 0, 0, 0, 0));
  endtask

  task automatic start();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n_instr);
    repeat (3 * n_instr) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog();
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 0);
    chk("R1 ac after reset", ac_o, 0);
    chk("R1 ax after reset", ax_o, 0);
  endtask

  task automatic t_add();
    begin_prog();
    load(1, 10, 200); load(1, 11, 100);
    load(0, 0, enc(0, 10, 0, 0, 0));
    load(0, 1, enc(0, 11, 0, 0, 0));
    start();
    run(1);
    chk("R3 add first", ac_o, 200);
    run(1);
    chk("R3 add wraps", ac_o, 44);
    chk("R11 pc after two", pc_o, 2);
  endtask

  task automatic t_store();
    begin_prog();
    load(1, 10, 77);
    load(0, 0, enc(0, 10, 0, 0, 0));
    load(0, 1, enc(1, 12, 0, 0, 0));
    load(0, 2, enc(0, 12, 0, 0, 0));
    start();
    run(2);
    chk("R4 ac cleared", ac_o, 0);
    run(1);
    chk("R4 stored word", ac_o, 77);
    chk("R2 pc", pc_o, 3);
  endtask

  task automatic t_incz();
    begin_prog();
    load(1, 5, 255); load(1, 6, 3);
    load(0, 0, enc(2, 5, 0, 0, 0));
    load(0, 1, enc(0, 6, 0, 0, 0));
    load(0, 2, enc(2, 6, 0, 0, 0));
    load(0, 4, enc(0, 6, 0, 0, 0));
    load(0, 5, enc(0, 5, 0, 0, 0));
    start();
    run(1);
    chk("R5 skip on zero", pc_o, 2);
    chk("R5 ac untouched", ac_o, 0);
    run(1);
    chk("R5 no skip", pc_o, 3);
    run(2);
    chk("R5 incremented word", ac_o, 4);
    run(1);
    chk("R5 wrapped word", ac_o, 4);
  endtask

  task automatic t_jump();
    begin_prog();
    load(1, 10, 9);
    load(0, 0, enc(3, 6, 1, 1, 1));
    load(0, 6, enc(0, 10, 0, 0, 0));
    start();
    run(1);
    chk("R6 jump target", pc_o, 6);
    chk("R6 ac kept", ac_o, 0);
    run(1);
    chk("R6 executes target", ac_o, 9);
    chk("R6 pc after target", pc_o, 7);
  endtask

  task automatic t_oper();
    begin_prog();
    load(1, 10, 255);
    load(0, 0, enc(7, 0, 1, 0, 0));
    load(0, 1, enc(7, 0, 0, 0, 1));
    load(0, 2, enc(7, 0, 0, 1, 0));
    load(0, 3, enc(7, 0, 1, 0, 0));
    load(0, 4, enc(0, 10, 0, 0, 0));
    load(0, 5, enc(7, 0, 1, 1, 1));
    load(0, 6, enc(7, 0, 1, 0, 0));
    load(0, 7, enc(7, 0, 0, 1, 0));
    load(0, 8, enc(7, 0, 1, 0, 1));
    start();
    run(1);
    chk("R7 increment", ac_o, 1);
    run(1);
    chk("R9 swap ac", ac_o, 0);
    chk("R9 swap ax", ax_o, 1);
    run(1);
    chk("R8 skip on zero", pc_o, 4);
    run(2);
    // AC=255 with F0,F1,F2: wraps to 0, skips, and swaps
    chk("R8 increment then skip", pc_o, 7);
    chk("R9 ac after combined", ac_o, 1);
    chk("R9 ax after combined", ax_o, 0);
    run(1);
    chk("R8 no skip on nonzero", pc_o, 8);
    run(1);
    chk("R7 increment before swap ax", ax_o, 2);
    chk("R9 ac from ax", ac_o, 0);
  endtask

  task automatic t_reserved();
    begin_prog();
    load(1, 10, 33);
    load(0, 0, enc(0, 10, 0, 0, 0));
    load(0, 1, enc(4, 10, 1, 1, 1));
    load(0, 2, enc(5, 10, 1, 1, 1));
    load(0, 3, enc(6, 10, 1, 1, 1));
    load(0, 4, enc(0, 10, 0, 0, 0));
    start();
    run(4);
    chk("R10 ac held", ac_o, 33);
    chk("R10 ax held", ax_o, 0);
    chk("R10 pc advance", pc_o, 4);
    run(1);
    chk("R10 memory intact", ac_o, 66);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_store();
    t_incz();
    t_jump();
    t_oper();
    t_reserved();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule